// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the per-channel register file of a descriptor-driven DMA engine. Software reaches it over a 32-bit word-only request bus with a valid/ready handshake. Each channel owns a 128-byte window, and word index `req_addr[6:2]` selects a register inside it. The block holds a status word, a command pointer and three condition-select words. The select words feed the interrupt, branch and wait decisions of the descriptor sequencer.

Software changes status through a masked control write. The upper half of the written word picks which bits change and the lower half gives their new values. After the merge, the status bits interact: waking or running forces the channel active, pausing stops it, and dropping the run bit resets the active and dead flags.

The descriptor sequencer sits outside the block and reaches it through four inputs: kill, clear-wake, set branch-taken and clear branch-taken. The block drives three strobes toward it: start, flush and descriptor reload. The command pointer is locked while the channel runs.

Top module: `dmach_regfile`

## Requirements
- R1: After reset the status, command pointer and select registers are zero, every read returns zero, and `start_o`, `flush_req_o`, `reload_o`, `irq_o` and `rsp_valid` are low.
- R2: A write to word index 0 merges into status as `(value & mask) | (old & ~mask)`, where mask is `wdata[31:16] & 16'hF0FF` and value is `wdata[15:0]`. Only run (bit 15), pause (bit 14), flush (bit 13), wake (bit 12) and device status (bits 7:0) can change this way. Dead (bit 11), active (bit 10), branch-taken (bit 8) and bit 9 never follow the mask.
- R3: After the merge, these rules apply in order: wake set forces active to 1; run set forces active to 1 and clears dead; pause set clears active.
- R4: If run was 1 before a control write and is 0 after it, active and dead both end at 0.
- R5: In the cycle after a control write, `start_o` pulses for one cycle if the resulting status has active set. `flush_req_o` pulses for one cycle if the resulting status has flush set.
- R6: A write to word index 3 updates the command pointer only when run and active are both 0. The stored value has its low 4 bits cleared, and `reload_o` pulses in the next cycle. While run or active is set, the write leaves the pointer unchanged and raises no reload.
- R7: Reads return the following. Index 0 reads zero. Index 1 reads status zero-extended to 32 bits. Index 3 reads the pointer. Indices 4, 5 and 6 read the interrupt, branch and wait select words. All other indices read zero and ignore writes. A write to index 4, 5 or 6 stores all 32 bits.
- R8: `req_ready` is always high. `rsp_valid` is high exactly in the cycle after an accepted read, and `rsp_rdata` then holds the read value.
- R9: `seq_kill` sets dead and clears active after any same-cycle bus write, and `irq_o` pulses in the next cycle.
- R10: `seq_clr_wake` clears wake. `seq_set_bt` sets branch-taken, and `seq_clr_bt` clears it, with set winning over clear. Both override a same-cycle bus write to status.
- R11: A write to word index 1 replaces status with `wdata[15:0]`, with none of the rules of R3 or R4 applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address inside the channel window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| seq_kill | input | 1 | Sequencer kills the channel |
| seq_clr_wake | input | 1 | Sequencer clears wake on command fetch |
| seq_set_bt | input | 1 | Sequencer sets branch-taken |
| seq_clr_bt | input | 1 | Sequencer clears branch-taken |
| status_o | output | 16 | Current status word |
| cmd_ptr_o | output | 32 | Current command pointer |
| intr_sel_o | output | 32 | Interrupt condition select |
| br_sel_o | output | 32 | Branch condition select |
| wait_sel_o | output | 32 | Wait condition select |
| start_o | output | 1 | Start pulse toward the sequencer |
| flush_req_o | output | 1 | Flush request pulse |
| reload_o | output | 1 | Descriptor reload pulse |
| irq_o | output | 1 | Interrupt pulse on kill |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. This covers status, pointer and select updates, the start, flush, reload and interrupt pulses, and the read response. The bench drives each request and sequencer input on a falling edge, releases it on the next falling edge, and samples all outputs at that same falling edge. That sample lies half a period after the single edge that registers the result. Pulses are also checked to be absent on the next sampled cycle where a rule says they must not fire. Ignored writes are confirmed by reading the same index back and by watching the pointer and status ports.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int STAT_W   = 16;
  localparam int B_RUN    = 15;
  localparam int B_PAUSE  = 14;
  localparam int B_FLUSH  = 13;
  localparam int B_WAKE   = 12;
  localparam int B_DEAD   = 11;
  localparam int B_ACTIVE = 10;
  localparam int B_BT     = 8;
  localparam logic [STAT_W-1:0] CTRL_WRITABLE = 16'hF0FF;

  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_PTR  = 3;
  localparam int IDX_ISEL = 4;
  localparam int IDX_BSEL = 5;
  localparam int IDX_WSEL = 6;

  // R2/R3/R4: masked merge followed by the ordered implication rules
  function automatic logic [STAT_W-1:0] ctrl_merge(input logic [STAT_W-1:0] old,
                                                   input logic [31:0] wr);
    logic [STAT_W-1:0] m;
    logic [STAT_W-1:0] n;
    m = wr[31:16] & CTRL_WRITABLE;
    n = (wr[15:0] & m) | (old & ~m);
    if (n[B_WAKE]) n[B_ACTIVE] = 1'b1;
    if (n[B_RUN]) begin
      n[B_ACTIVE] = 1'b1;
      n[B_DEAD]   = 1'b0;
    end
    if (n[B_PAUSE]) n[B_ACTIVE] = 1'b0;
    if (old[B_RUN] && !n[B_RUN]) begin
      n[B_ACTIVE] = 1'b0;
      n[B_DEAD]   = 1'b0;
    end
    return n;
  endfunction
endpackage

// File: rtl/dmach_status.sv
module dmach_status
  import dmach_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              stat_wr,
  input  logic [31:0]       wdata,
  input  logic              kill,
  input  logic              clr_wake,
  input  logic              set_bt,
  input  logic              clr_bt,
  output logic [STAT_W-1:0] status_q,
  output logic              start_o,
  output logic              flush_req_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] ctrl_merged;
  logic [STAT_W-1:0] after_bus;
  logic [STAT_W-1:0] status_d;

  assign ctrl_merged = ctrl_merge(status_q, wdata);

  always_comb begin
    after_bus = status_q;
    if (ctrl_wr)      after_bus = ctrl_merged;        // R2
    else if (stat_wr) after_bus = wdata[STAT_W-1:0];  // R11
    status_d = after_bus;
    if (kill) begin                                   // R9
      status_d[B_DEAD]   = 1'b1;
      status_d[B_ACTIVE] = 1'b0;
    end
    if (clr_wake) status_d[B_WAKE] = 1'b0;            // R10
    if (set_bt)      status_d[B_BT] = 1'b1;
    else if (clr_bt) status_d[B_BT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q    <= '0;
      start_o     <= 1'b0;
      flush_req_o <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      status_q    <= status_d;
      start_o     <= ctrl_wr && status_d[B_ACTIVE];   // R5
      flush_req_o <= ctrl_wr && status_d[B_FLUSH];
      irq_o       <= kill;
    end
  end

  assert_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (status_q[B_DEAD] && !status_q[B_ACTIVE] && irq_o));
  assert_start_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> status_q[B_ACTIVE]);
  assert_flush_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req_o |-> status_q[B_FLUSH]);
  assert_pause_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[16+B_PAUSE] && wdata[B_PAUSE]) |=> !status_q[B_ACTIVE]);
  assert_run_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !kill && status_q[B_RUN] && wdata[16+B_RUN] && !wdata[B_RUN])
      |=> (!status_q[B_ACTIVE] && !status_q[B_DEAD]));
  assert_set_bt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_bt |=> status_q[B_BT]);
  assert_clr_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wake |=> !status_q[B_WAKE]);
endmodule

// File: rtl/dmach_cmdptr.sv
module dmach_cmdptr #(
  parameter int DATA_W    = 32,
  parameter int ALIGN_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              locked,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ptr_q,
  output logic              reload_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~((DATA_W'(1) << ALIGN_LSB) - DATA_W'(1));

  logic accept;
  assign accept = wr && !locked;   // R6 lock

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      reload_o <= 1'b0;
    end else begin
      if (accept) ptr_q <= wdata & KEEP_MASK;
      reload_o <= accept;
    end
  end

  assert_ptr_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked) |=> ($stable(ptr_q) && !reload_o));
  assert_ptr_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |-> (ptr_q[ALIGN_LSB-1:0] == '0));
  assert_ptr_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ptr_q[DATA_W-1:ALIGN_LSB] == $past(wdata[DATA_W-1:ALIGN_LSB])));
endmodule

// File: rtl/dmach_selbank.sv
module dmach_selbank #(
  parameter int DATA_W = 32,
  parameter int N_SEL  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SEL-1:0]              wr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [N_SEL-1:0][DATA_W-1:0]  sel_q
);
  for (genvar g = 0; g < N_SEL; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)     sel_q[g] <= '0;
      else if (wr[g]) sel_q[g] <= wdata;
    end

    assert_sel_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr[g] |=> (sel_q[g] == $past(wdata)));
  end
endmodule

// File: rtl/dmach_regfile.sv
module dmach_regfile
  import dmach_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int PTR_ALIGN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              seq_kill,
  input  logic              seq_clr_wake,
  input  logic              seq_set_bt,
  input  logic              seq_clr_bt,
  output logic [STAT_W-1:0] status_o,
  output logic [DATA_W-1:0] cmd_ptr_o,
  output logic [DATA_W-1:0] intr_sel_o,
  output logic [DATA_W-1:0] br_sel_o,
  output logic [DATA_W-1:0] wait_sel_o,
  output logic              start_o,
  output logic              flush_req_o,
  output logic              reload_o,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int N_SEL = 3;

  logic [IDX_W-1:0] idx;
  logic             rd_acc, wr_acc;
  logic             hit_ctrl, hit_stat, hit_ptr, hit_isel, hit_bsel, hit_wsel;
  logic [N_SEL-1:0] sel_wr;
  logic [N_SEL-1:0][DATA_W-1:0] sel_q;
  logic [DATA_W-1:0] rd_mux;
  logic             addr_lo_unused;

  assign req_ready      = 1'b1;                        // R8
  assign idx            = req_addr[ADDR_W-1:2];
  assign addr_lo_unused = ^req_addr[1:0];
  assign rd_acc         = req_valid && req_ready && !req_write;
  assign wr_acc         = req_valid && req_ready && req_write;

  assign hit_ctrl = (int'(idx) == IDX_CTRL);
  assign hit_stat = (int'(idx) == IDX_STAT);
  assign hit_ptr  = (int'(idx) == IDX_PTR);
  assign hit_isel = (int'(idx) == IDX_ISEL);
  assign hit_bsel = (int'(idx) == IDX_BSEL);
  assign hit_wsel = (int'(idx) == IDX_WSEL);
  assign sel_wr   = {wr_acc && hit_wsel, wr_acc && hit_bsel, wr_acc && hit_isel};

  dmach_status u_status (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr_acc && hit_ctrl), .stat_wr(wr_acc && hit_stat),
    .wdata(req_wdata[31:0]),
    .kill(seq_kill), .clr_wake(seq_clr_wake), .set_bt(seq_set_bt), .clr_bt(seq_clr_bt),
    .status_q(status_o), .start_o(start_o), .flush_req_o(flush_req_o), .irq_o(irq_o)
  );

  dmach_cmdptr #(.DATA_W(DATA_W), .ALIGN_LSB(PTR_ALIGN)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_acc && hit_ptr),
    .locked(status_o[B_RUN] || status_o[B_ACTIVE]),
    .wdata(req_wdata), .ptr_q(cmd_ptr_o), .reload_o(reload_o)
  );

  dmach_selbank #(.DATA_W(DATA_W), .N_SEL(N_SEL)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(req_wdata), .sel_q(sel_q)
  );

  assign intr_sel_o = sel_q[0];
  assign br_sel_o   = sel_q[1];
  assign wait_sel_o = sel_q[2];

  // R7: read decode; control and unlisted indices read zero
  always_comb begin
    rd_mux = '0;
    if (hit_stat)      rd_mux = {{(DATA_W-STAT_W){1'b0}}, status_o};
    else if (hit_ptr)  rd_mux = cmd_ptr_o;
    else if (hit_isel) rd_mux = sel_q[0];
    else if (hit_bsel) rd_mux = sel_q[1];
    else if (hit_wsel) rd_mux = sel_q[2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;                         // R8
      if (rd_acc) rsp_rdata <= rd_mux;
    end
  end

  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  assert_rsp_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);
  assert_ctrl_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && hit_ctrl) |=> (rsp_rdata == '0));
endmodule

// File: tb/sim_dmach_regfile.sv
module sim_dmach_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_ready, req_write;
  logic [6:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        seq_kill, seq_clr_wake, seq_set_bt, seq_clr_bt;
  logic [15:0] status_o;
  logic [31:0] cmd_ptr_o, intr_sel_o, br_sel_o, wait_sel_o;
  logic        start_o, flush_req_o, reload_o, irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dmach_regfile u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .seq_kill(seq_kill), .seq_clr_wake(seq_clr_wake), .seq_set_bt(seq_set_bt),
    .seq_clr_bt(seq_clr_bt), .status_o(status_o), .cmd_ptr_o(cmd_ptr_o),
    .intr_sel_o(intr_sel_o), .br_sel_o(br_sel_o), .wait_sel_o(wait_sel_o),
    .start_o(start_o), .flush_req_o(flush_req_o), .reload_o(reload_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    seq_kill = 0; seq_clr_wake = 0; seq_set_bt = 0; seq_clr_bt = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic set_write(input int idx, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = 7'(idx * 4); req_wdata = d;
  endtask

  task automatic do_write(input int idx, input logic [31:0] d);
    set_write(idx, d);
    step();
  endtask

  task automatic do_read(input int idx, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = 7'(idx * 4);
    step();
    check("R8 rsp_valid after read", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
  endtask

  // Bench-side model of the control write (R2, R3, R4)
  function automatic logic [15:0] model_ctrl(input logic [15:0] old, input logic [31:0] w);
    logic [15:0] wm, n;
    logic act, dead, run_now;
    wm = w[31:16] & 16'hF0FF;
    n = old ^ ((old ^ w[15:0]) & wm);
    run_now = n[15];
    act = n[10] | n[12] | run_now;
    dead = n[11] & ~run_now;
    if (n[14]) act = 1'b0;
    if (old[15] & ~run_now) begin act = 1'b0; dead = 1'b0; end
    n[10] = act;
    n[11] = dead;
    return n;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd, p_exp;
    logic [15:0] old, e;
    logic [31:0] w;
    idle();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", 32'(status_o), 0);
    check("R1 ptr", cmd_ptr_o, 0);
    check("R1 sels", intr_sel_o | br_sel_o | wait_sel_o, 0);
    check("R1 strobes", {28'd0, start_o, flush_req_o, reload_o, irq_o}, 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R8 ready", 32'(req_ready), 1);
    for (int i = 0; i < 8; i++) begin
      do_read(i, rd);
      check("R1 read zero", rd, 0);
    end

    // R3 directed cases
    do_write(0, 32'h1000_1000);
    check("R3 wake forces active", 32'(status_o), 32'h1400);
    check("R5 start on wake", 32'(start_o), 1);
    step();
    check("R5 start is one pulse", 32'(start_o), 0);
    do_write(1, 0);
    do_write(0, 32'h5000_5000);
    check("R3 pause beats wake", 32'(status_o), 32'h5000);
    check("R5 no start when paused", 32'(start_o), 0);
    do_write(1, 32'h0800);
    do_write(0, 32'h8000_8000);
    check("R3 run clears dead", 32'(status_o), 32'h8400);

    // R4 run falling
    do_write(1, 32'h8C00);
    do_write(0, 32'h8000_0000);
    check("R4 run fall clears active and dead", 32'(status_o), 0);

    // R11 direct status write skips rules
    do_write(1, 32'hFFFF_9A5C);
    check("R11 raw status", 32'(status_o), 32'h9A5C);

    // R2..R5 sweep: start states x mask nibble x value nibble
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 16; m++) begin
        for (int v = 0; v < 16; v++) begin
          old = 16'h00A5 | (s[0] ? 16'h8000 : 16'h0) | (s[1] ? 16'h0400 : 16'h0)
              | (s[2] ? 16'h0800 : 16'h0) | ((s[0] ^ s[1]) ? 16'h0100 : 16'h0);
          do_write(1, {16'h0, old});
          check("R11 status load", 32'(status_o), 32'(old));
          w = {4'(m), 4'hF, (m[0] ? 8'hF0 : 8'h00),
               4'(v), ~old[11:8], 8'h3C};
          e = model_ctrl(old, w);
          do_write(0, w);
          check(old[15] ? "R4 merged status" : "R2 merged status", 32'(status_o), 32'(e));
          check("R5 start", 32'(start_o), 32'(e[10]));
          check("R5 flush", 32'(flush_req_o), 32'(e[13]));
        end
      end
    end

    // R6 command pointer
    do_write(1, 0);
    for (int k = 0; k < 16; k++) begin
      p_exp = 32'h1234_5670 + 32'(k * 16);
      do_write(3, p_exp | 32'(k));
      check("R6 ptr aligned", cmd_ptr_o, p_exp);
      check("R6 reload pulse", 32'(reload_o), 1);
      step();
      check("R6 reload single", 32'(reload_o), 0);
    end
    do_read(3, rd);
    check("R7 ptr readback", rd, p_exp);
    do_write(1, 32'h0400);
    do_write(3, 32'hDEAD_BEE0);
    check("R6 locked by active", cmd_ptr_o, p_exp);
    check("R6 no reload when active", 32'(reload_o), 0);
    do_write(1, 32'h8000);
    do_write(3, 32'hDEAD_BEE0);
    check("R6 locked by run", cmd_ptr_o, p_exp);
    check("R6 no reload when running", 32'(reload_o), 0);

    // R7 selects, control read, ignored indices
    do_write(4, 32'h000F_0003);
    do_write(5, 32'h00A0_0050);
    do_write(6, 32'hC001_D00D);
    check("R7 intr sel", intr_sel_o, 32'h000F_0003);
    check("R7 branch sel", br_sel_o, 32'h00A0_0050);
    check("R7 wait sel", wait_sel_o, 32'hC001_D00D);
    do_read(5, rd);
    check("R7 branch sel read", rd, 32'h00A0_0050);
    do_read(0, rd);
    check("R7 control reads zero", rd, 0);
    do_read(1, rd);
    check("R7 status read", rd, 32'h8000);
    for (int i = 2; i < 32; i++) begin
      if (i == 3 || i == 4 || i == 5 || i == 6) continue;
      do_write(i, 32'hFFFF_FFFF);
      check("R8 no rsp on write", 32'(rsp_valid), 0);
      do_read(i, rd);
      check("R7 ignored index reads zero", rd, 0);
    end
    check("R7 ptr untouched", cmd_ptr_o, p_exp);
    check("R7 status untouched", 32'(status_o), 32'h8000);

    // R9 kill
    do_write(1, 32'h8400);
    seq_kill = 1;
    step();
    check("R9 kill status", 32'(status_o), 32'h8800);
    check("R9 irq pulse", 32'(irq_o), 1);
    step();
    check("R9 irq single", 32'(irq_o), 0);
    do_write(1, 0);
    set_write(0, 32'h8000_8000);
    seq_kill = 1;
    step();
    check("R9 kill beats run write", 32'(status_o), 32'h8800);
    check("R9 no start when killed", 32'(start_o), 0);

    // R10 hooks
    do_write(1, 0);
    set_write(1, 32'h0000_1100);
    seq_clr_wake = 1; seq_clr_bt = 1;
    step();
    check("R10 clears beat status write", 32'(status_o), 0);
    set_write(1, 0);
    seq_set_bt = 1; seq_clr_bt = 1;
    step();
    check("R10 set wins", 32'(status_o), 32'h0100);
    seq_clr_bt = 1;
    step();
    check("R10 clear bt", 32'(status_o), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule